// File: doc/BRIEF.md
# Per-Core Idle Power-Down Sequencer

This block walks each of up to four processor cores through an idle power-down and back out again. Each core has its own bank of registers. Software fills in that bank and then sets a power-down request. The core's sequencer then waits for the core to signal that it is stalled on wait-for-interrupt, if that wait is enabled. It can also wait for the core's snoop queue to drain. Only after those waits does it raise the core's power-off output.

A shared L2 power-off output rises when two things hold: deep idle is permitted globally, and every requesting core is powered off with its L2 request set. While a core is off, enabled interrupt, fast-interrupt or debug events wake it. The core is then released with a one-cycle pulse and fetches from its programmable restart address. Independently of the sequencer, two status bits can block interrupt and fast-interrupt delivery to the core.

The register port is a single-cycle write strobe with a combinational read. A write takes effect at the clock edge that samples `bus_wr`. Unused register bits, and unmapped offsets, read as zero.

Top module: `cpu_idle_seq`

## Requirements
- R1: After synchronous reset every register reads zero and every power-off, release, L2 power-off and masked-interrupt output is low.
- R2: Register map, with core c's bank at base 0x100*(c+1):
  - Base+0x04 is the control register: bit 16 requests power-down and bit 20 requests L2 power-down.
  - Base+0x08 bit 0 bypasses the snoop handshake.
  - Base+0x0C is status/mask: bit 16 is the WFI wait, bit 17 the snoop wait, bits 20/21/22 the interrupt/fast-interrupt/debug wake enables, and bits 24/25 block interrupt/fast-interrupt.
  - Base+0x24 is the 32-bit restart address.
  - The global deep-idle permit is bit 20 of offset 0x004.
  - Every other bit and offset reads zero.
- R3: With the WFI wait bit set, a requested core does not power off while its WFI input is low. It powers off in the cycle after WFI is seen high. With the bit clear, it powers off three cycles after the request write without regard to WFI.
- R4: With the snoop wait bit set and the bypass bit clear, power-off also waits for the snoop-empty input. Setting the bypass bit removes that wait.
- R5: If WFI drops while the core waits for the snoop queue, the core does not power off, and the request bit still reads back set.
- R6: A powered-off core wakes only on an interrupt, fast-interrupt or debug input whose wake-enable bit is set. Events that are not enabled leave it off.
- R7: A wake event at a clock edge drops the core's power-off output and raises its release output for exactly one cycle. During that cycle the restart-address output equals the core's restart register.
- R8: A core's interrupt output follows its interrupt input unless status bit 24 is set. Its fast-interrupt output follows its input unless bit 25 is set.
- R9: The L2 power-off output is high only when all of the following hold: the deep-idle permit is set, at least one core requests power-down, and every requesting core is off with its L2 bit set.
- R10: The L2 power-off output falls in the cycle after a wake event takes any of the contributing cores out of power-off.
- R11: Clearing the request before power-off returns the core to running, and a later WFI does not power it off. Clearing the request while the core is off leaves it off until a wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_wfi | input | NCORE | Per-core wait-for-interrupt indication |
| cpu_snoop_empty | input | NCORE | Per-core snoop queue empty indication |
| cpu_irq | input | NCORE | Per-core interrupt request |
| cpu_fiq | input | NCORE | Per-core fast interrupt request |
| cpu_dbg | input | NCORE | Per-core debug request |
| core_irq | output | NCORE | Interrupt delivered to the core after masking |
| core_fiq | output | NCORE | Fast interrupt delivered to the core after masking |
| core_pwr_off | output | NCORE | Core power-off command |
| core_release | output | NCORE | One-cycle release pulse on wake |
| core_boot_addr | output | 32*NCORE | Per-core restart address, core c in bits [32c+31:32c] |
| l2_pwr_off | output | 1 | Shared L2 cache and fabric power-off command |

## Verification
The hardest case to reach is the one where WFI drops while the core is waiting for the snoop queue. The bench holds WFI high and snoop-empty low until the core has reached that wait. It then drops WFI and only afterwards raises snoop-empty, so a design that missed the fall-back would power off at that point. The L2 output needs several cores in chosen states at once. The bench therefore parks one core off with its L2 bit set. It then brings a second core off without that bit, and later sets the bit while that core is already off, before waking one of them.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_ARMED      = 3'd1,
        ST_WAIT_WFI   = 3'd2,
        ST_WAIT_SNOOP = 3'd3,
        ST_OFF        = 3'd4,
        ST_WAKE       = 3'd5
    } seq_state_e;

    // offsets inside a core bank; bank index = core + 1
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_PDC    = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h0C;
    localparam logic [7:0] OFS_BOOT   = 8'h24;
    localparam logic [7:0] OFS_FABRIC = 8'h04;  // in bank 0

    localparam int CTL_PD_BIT   = 16;
    localparam int CTL_L2_BIT   = 20;
    localparam int PDC_SKIP_BIT = 0;
    localparam int ST_WFI_BIT   = 16;
    localparam int ST_SNP_BIT   = 17;
    localparam int ST_WAKE_LSB  = 20;
    localparam int ST_MIRQ_BIT  = 24;
    localparam int ST_MFIQ_BIT  = 25;
    localparam int FAB_L2_BIT   = 20;

    typedef struct packed {
        logic       pd_req;
        logic       l2_req;
        logic       skip_snoop;
        logic       wait_wfi;
        logic       wait_snoop;
        logic [2:0] wake_en;    // [0] irq, [1] fiq, [2] debug
        logic       mask_irq;
        logic       mask_fiq;
    } core_cfg_t;

    function automatic logic [31:0] ctrl_word(core_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_PD_BIT] = c.pd_req;
        w[CTL_L2_BIT] = c.l2_req;
        return w;
    endfunction

    function automatic logic [31:0] stat_word(core_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[ST_WFI_BIT] = c.wait_wfi;
        w[ST_SNP_BIT] = c.wait_snoop;
        w[ST_WAKE_LSB +: 3] = c.wake_en;
        w[ST_MIRQ_BIT] = c.mask_irq;
        w[ST_MFIQ_BIT] = c.mask_fiq;
        return w;
    endfunction

    function automatic logic [31:0] pdc_word(core_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[PDC_SKIP_BIT] = c.skip_snoop;
        return w;
    endfunction

endpackage

// File: rtl/idle_regs.sv
module idle_regs
    import idle_seq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int AW    = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output core_cfg_t             cfg [NCORE],
    output logic [NCORE-1:0][31:0] boot,
    output logic                  fabric_en
);
    localparam int BW = AW - 8;

    logic [BW-1:0]          bank;
    logic [7:0]             ofs;
    logic [NCORE:0][31:0]   rd_part;

    assign bank = addr[AW-1:8];
    assign ofs  = addr[7:0];

    always_ff @(posedge clk) begin
        if (rst)
            fabric_en <= 1'b0;
        else if (wr_en && bank == '0 && ofs == OFS_FABRIC)
            fabric_en <= wdata[FAB_L2_BIT];
    end

    assign rd_part[0] = (bank == '0 && ofs == OFS_FABRIC) ?
                        (32'(fabric_en) << FAB_L2_BIT) : 32'd0;

    for (genvar c = 0; c < NCORE; c++) begin : g_bank
        logic        sel;
        core_cfg_t   cfg_q;
        logic [31:0] boot_q;
        logic [31:0] rd;

        assign sel = (bank == BW'(c + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q  <= '0;
                boot_q <= '0;
            end else if (wr_en && sel) begin
                case (ofs)
                    OFS_CTRL: begin
                        cfg_q.pd_req <= wdata[CTL_PD_BIT];
                        cfg_q.l2_req <= wdata[CTL_L2_BIT];
                    end
                    OFS_PDC:  cfg_q.skip_snoop <= wdata[PDC_SKIP_BIT];
                    OFS_STAT: begin
                        cfg_q.wait_wfi   <= wdata[ST_WFI_BIT];
                        cfg_q.wait_snoop <= wdata[ST_SNP_BIT];
                        cfg_q.wake_en    <= wdata[ST_WAKE_LSB +: 3];
                        cfg_q.mask_irq   <= wdata[ST_MIRQ_BIT];
                        cfg_q.mask_fiq   <= wdata[ST_MFIQ_BIT];
                    end
                    OFS_BOOT: boot_q <= wdata;
                    default: ;
                endcase
            end
        end

        always_comb begin
            rd = '0;
            if (sel) begin
                case (ofs)
                    OFS_CTRL: rd = ctrl_word(cfg_q);
                    OFS_PDC:  rd = pdc_word(cfg_q);
                    OFS_STAT: rd = stat_word(cfg_q);
                    OFS_BOOT: rd = boot_q;
                    default:  rd = '0;
                endcase
            end
        end

        assign rd_part[c+1] = rd;
        assign cfg[c]       = cfg_q;
        assign boot[c]      = boot_q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i <= NCORE; i++)
            rdata = rdata | rd_part[i];
    end

endmodule

// File: rtl/idle_core_fsm.sv
module idle_core_fsm
    import idle_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  core_cfg_t cfg,
    input  logic      wfi,
    input  logic      snoop_empty,
    input  logic      irq,
    input  logic      fiq,
    input  logic      dbg,
    output logic      pwr_off,
    output logic      release_pulse,
    output logic      l2_vote,
    output logic      irq_out,
    output logic      fiq_out
);
    seq_state_e state, nxt;
    logic       wfi_ok;
    logic       snoop_need;
    logic       wake_evt;

    assign wfi_ok     = !cfg.wait_wfi || wfi;
    assign snoop_need = cfg.wait_snoop && !cfg.skip_snoop;
    assign wake_evt   = |(cfg.wake_en & {dbg, fiq, irq});

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (cfg.pd_req) nxt = ST_ARMED;
            ST_ARMED:    nxt = cfg.pd_req ? ST_WAIT_WFI : ST_RUN;
            ST_WAIT_WFI: begin
                if (!cfg.pd_req)  nxt = ST_RUN;
                else if (wfi_ok)  nxt = snoop_need ? ST_WAIT_SNOOP : ST_OFF;
            end
            ST_WAIT_SNOOP: begin
                if (!cfg.pd_req)      nxt = ST_RUN;
                else if (!wfi_ok)     nxt = ST_ARMED;
                else if (snoop_empty) nxt = ST_OFF;
            end
            ST_OFF:      if (wake_evt) nxt = ST_WAKE;
            ST_WAKE:     nxt = ST_RUN;
            default:     nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= nxt;
    end

    assign pwr_off       = (state == ST_OFF);
    assign release_pulse = (state == ST_WAKE);
    assign l2_vote       = pwr_off && cfg.l2_req;
    assign irq_out       = irq && !cfg.mask_irq;
    assign fiq_out       = fiq && !cfg.mask_fiq;

    // R3: power-off only once the WFI condition held
    a_r3_off_after_wfi: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_off) |-> $past(!cfg.wait_wfi || wfi));

    // R4: snoop handshake honoured unless bypassed
    a_r4_off_after_drain: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwr_off) && $past(cfg.wait_snoop && !cfg.skip_snoop)) |-> $past(snoop_empty));

    // R11: no power-off without a live request
    a_r11_off_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_off) |-> $past(cfg.pd_req));

    // R7: release follows an enabled wake event while off
    a_r7_release_after_wake: assert property (@(posedge clk) disable iff (rst)
        release_pulse |-> ($past(pwr_off) && $past(|(cfg.wake_en & {dbg, fiq, irq}))));

    // R7: release lasts one cycle
    a_r7_release_single: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse);

endmodule

// File: rtl/idle_l2_gate.sv
module idle_l2_gate #(
    parameter int NCORE = 4
) (
    input  logic             fabric_en,
    input  logic [NCORE-1:0] req,
    input  logic [NCORE-1:0] vote,
    output logic             l2_off
);
    logic all_ready;

    always_comb begin
        all_ready = 1'b1;
        for (int i = 0; i < NCORE; i++)
            if (req[i] && !vote[i]) all_ready = 1'b0;
    end

    assign l2_off = fabric_en && (|req) && all_ready;

endmodule

// File: rtl/cpu_idle_seq.sv
module cpu_idle_seq
    import idle_seq_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int AW    = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NCORE-1:0]   cpu_wfi,
    input  logic [NCORE-1:0]   cpu_snoop_empty,
    input  logic [NCORE-1:0]   cpu_irq,
    input  logic [NCORE-1:0]   cpu_fiq,
    input  logic [NCORE-1:0]   cpu_dbg,
    output logic [NCORE-1:0]   core_irq,
    output logic [NCORE-1:0]   core_fiq,
    output logic [NCORE-1:0]   core_pwr_off,
    output logic [NCORE-1:0]   core_release,
    output logic [32*NCORE-1:0] core_boot_addr,
    output logic               l2_pwr_off
);
    core_cfg_t              cfg [NCORE];
    logic [NCORE-1:0][31:0] boot;
    logic                   fabric_en;
    logic [NCORE-1:0]       req_vec;
    logic [NCORE-1:0]       vote_vec;

    idle_regs #(.NCORE(NCORE), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .cfg       (cfg),
        .boot      (boot),
        .fabric_en (fabric_en)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign req_vec[c] = cfg[c].pd_req;
        idle_core_fsm u_fsm (
            .clk           (clk),
            .rst           (rst),
            .cfg           (cfg[c]),
            .wfi           (cpu_wfi[c]),
            .snoop_empty   (cpu_snoop_empty[c]),
            .irq           (cpu_irq[c]),
            .fiq           (cpu_fiq[c]),
            .dbg           (cpu_dbg[c]),
            .pwr_off       (core_pwr_off[c]),
            .release_pulse (core_release[c]),
            .l2_vote       (vote_vec[c]),
            .irq_out       (core_irq[c]),
            .fiq_out       (core_fiq[c])
        );
    end

    assign core_boot_addr = boot;

    idle_l2_gate #(.NCORE(NCORE)) u_l2 (
        .fabric_en (fabric_en),
        .req       (req_vec),
        .vote      (vote_vec),
        .l2_off    (l2_pwr_off)
    );

    // R9: L2 off only with permit and every requester powered off
    a_r9_l2_all_off: assert property (@(posedge clk) disable iff (rst)
        l2_pwr_off |-> (fabric_en && (&(core_pwr_off | ~req_vec))));

    // R10: a released core cannot leave L2 off if it still requests
    a_r10_l2_drop_on_wake: assert property (@(posedge clk) disable iff (rst)
        (|(core_release & req_vec)) |-> !l2_pwr_off);

endmodule

// File: tb/sim_cpu_idle_seq.sv
module sim_cpu_idle_seq;
    localparam int N = 4;

    logic            clk = 0;
    logic            rst = 1;
    logic            bus_wr = 0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    wfi = '0, snp = '0, irq = '0, fiq = '0, dbg = '0;
    logic [N-1:0]    c_irq, c_fiq, off, rel;
    logic [32*N-1:0] boot;
    logic            l2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpu_idle_seq u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_wfi(wfi), .cpu_snoop_empty(snp), .cpu_irq(irq),
        .cpu_fiq(fiq), .cpu_dbg(dbg), .core_irq(c_irq), .core_fiq(c_fiq),
        .core_pwr_off(off), .core_release(rel), .core_boot_addr(boot),
        .l2_pwr_off(l2)
    );

    // address, write data, expected read-back
    localparam logic [75:0] VEC [11] = '{
        {12'h004, 32'hFFFFFFFF, 32'h00100000},
        {12'h004, 32'h00000000, 32'h00000000},
        {12'h108, 32'hFFFFFFFF, 32'h00000001},
        {12'h108, 32'h00000000, 32'h00000000},
        {12'h10C, 32'hFFFFFFFF, 32'h03730000},
        {12'h10C, 32'h00000000, 32'h00000000},
        {12'h324, 32'hDEADBEEF, 32'hDEADBEEF},
        {12'h424, 32'h12345678, 32'h12345678},
        {12'h204, 32'h00100000, 32'h00100000},
        {12'h204, 32'h00000000, 32'h00000000},
        {12'h110, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        chk("R1 outputs", {16'd0, off, rel, c_irq, c_fiq}, 32'd0);
        chk("R1 l2", 32'(l2), 32'd0);
        rd(12'h104, v); chk("R1 ctrl0", v, 32'd0);
        rd(12'h424, v); chk("R1 boot3", v, 32'd0);

        // R2 register map vectors
        for (int i = 0; i < 11; i++) begin
            wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], v);
            chk($sformatf("R2 vec%0d", i), v, VEC[i][31:0]);
        end

        // R3 WFI wait, R6 and R7 wake
        wr(12'h10C, 32'h00110000);
        wr(12'h124, 32'h00008000);
        wr(12'h104, 32'h00010000);
        tick(4);
        chk("R3 waits wfi", 32'(off[0]), 32'd0);
        wfi[0] = 1;
        tick(1);
        chk("R3 off after wfi", 32'(off[0]), 32'd1);
        dbg[0] = 1;
        tick(2);
        chk("R6 debug not enabled", 32'(off[0]), 32'd1);
        dbg[0] = 0;
        irq[0] = 1;
        tick(1);
        chk("R7 release", 32'(rel[0]), 32'd1);
        chk("R7 off dropped", 32'(off[0]), 32'd0);
        chk("R7 boot addr", boot[31:0], 32'h00008000);
        irq[0] = 0; wfi[0] = 0;
        tick(1);
        chk("R7 single pulse", 32'(rel[0]), 32'd0);
        rd(12'h104, v); chk("R5 request kept", v, 32'h00010000);
        wr(12'h104, 32'h0);

        // R11 clear before power-off
        wr(12'h10C, 32'h00110000);
        wr(12'h104, 32'h00010000);
        tick(3);
        wr(12'h104, 32'h0);
        tick(2);
        wfi[0] = 1;
        tick(4);
        chk("R11 no off after clear", 32'(off[0]), 32'd0);
        wfi[0] = 0;

        // R3 no WFI wait: off three cycles after write; R11 off holds
        wr(12'h10C, 32'h00100000);
        wr(12'h104, 32'h00010000);
        tick(2);
        chk("R3 not yet off", 32'(off[0]), 32'd0);
        tick(1);
        chk("R3 off without wfi", 32'(off[0]), 32'd1);
        wr(12'h104, 32'h0);
        chk("R11 off held after clear", 32'(off[0]), 32'd1);
        irq[0] = 1; tick(1); irq[0] = 0; tick(1);
        chk("R6 irq wake", 32'(off[0]), 32'd0);

        // R4 snoop wait, R5 WFI drop
        wr(12'h20C, 32'h00230000);
        wfi[1] = 1; snp[1] = 0;
        wr(12'h204, 32'h00010000);
        tick(5);
        chk("R4 waits snoop", 32'(off[1]), 32'd0);
        wfi[1] = 0;
        tick(2);
        snp[1] = 1;
        tick(4);
        chk("R5 no off after wfi drop", 32'(off[1]), 32'd0);
        rd(12'h204, v); chk("R5 request still set", v, 32'h00010000);
        wfi[1] = 1;
        tick(4);
        chk("R4 off after drain", 32'(off[1]), 32'd1);
        irq[1] = 1;
        tick(2);
        chk("R6 irq not enabled", 32'(off[1]), 32'd1);
        irq[1] = 0;
        fiq[1] = 1;
        tick(1);
        chk("R6 fiq wake", 32'(rel[1]), 32'd1);
        fiq[1] = 0; wfi[1] = 0; snp[1] = 0;
        wr(12'h204, 32'h0);

        // R4 bypass
        wr(12'h208, 32'h00000001);
        wfi[1] = 1;
        wr(12'h204, 32'h00010000);
        tick(4);
        chk("R4 bypass off", 32'(off[1]), 32'd1);
        wr(12'h204, 32'h0);
        fiq[1] = 1; tick(1); fiq[1] = 0; tick(1);
        chk("R4 bypass woke", 32'(off[1]), 32'd0);
        wr(12'h208, 32'h0);
        wfi[1] = 0;

        // R8 masking
        wr(12'h10C, 32'h01000000);
        irq[0] = 1; fiq[0] = 1;
        #1;
        chk("R8 irq masked", {30'd0, c_irq[0], c_fiq[0]}, 32'd1);
        wr(12'h10C, 32'h02000000);
        #1;
        chk("R8 fiq masked", {30'd0, c_irq[0], c_fiq[0]}, 32'd2);
        wr(12'h10C, 32'h0);
        #1;
        chk("R8 unmasked", {30'd0, c_irq[0], c_fiq[0]}, 32'd3);
        irq[0] = 0; fiq[0] = 0;

        // R9 and R10 L2 power-off
        wr(12'h30C, 32'h00400000);
        wr(12'h304, 32'h00110000);
        tick(4);
        chk("R9 core2 off", 32'(off[2]), 32'd1);
        chk("R9 no permit", 32'(l2), 32'd0);
        wr(12'h004, 32'h00100000);
        chk("R9 l2 off", 32'(l2), 32'd1);
        wr(12'h40C, 32'h00400000);
        wr(12'h404, 32'h00010000);
        chk("R9 core3 pending", 32'(l2), 32'd0);
        tick(4);
        chk("R9 core3 off", 32'(off[3]), 32'd1);
        chk("R9 core3 lacks L2 bit", 32'(l2), 32'd0);
        wr(12'h404, 32'h00110000);
        chk("R9 all voting", 32'(l2), 32'd1);
        wr(12'h404, 32'h0);
        chk("R9 core3 withdrawn", 32'(l2), 32'd1);
        dbg[2] = 1;
        tick(1);
        chk("R10 l2 drops on wake", 32'(l2), 32'd0);
        dbg[2] = 0;
        wr(12'h304, 32'h0);
        dbg[3] = 1; tick(1); dbg[3] = 0; tick(1);
        chk("R6 debug wake core3", 32'(off[3]), 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule